// File: doc/BRIEF.md
# Early-Forwarding Double-Error-Correcting Read Stage

This block sits on the read side of an SRAM and sits between the memory port and the logic that consumes the data. Each stored word carries 16 data bits and 10 check bits from a shortened double-error-correcting cyclic code. On every accepted read, a parity recomputation checks the word. This check costs about as much as the encoder. When the check finds nothing wrong, the data bits go out in the cycle right after capture, so an error-free read pays no latency beyond the syndrome check.

When the syndrome is nonzero, the stage stalls its consumer and stops accepting reads. During the stall the slower pattern decoder has time to settle, and its result is registered. After a fixed number of stall cycles, set by a parameter to 1 or 2, the stage presents the word for one cycle. Depending on the result, the word is either corrected and marked corrected, or left raw and marked uncorrectable. Two saturating counters keep a tally of corrected and uncorrectable deliveries. Most reads carry no error, so the average added latency stays close to zero.

Top module: `ecc_fwd_read`

## Requirements
- R1: While reset is held low at a clock edge, and after that edge, in_ready is 1, out_valid and out_stall are 0, and both counters read 0. This holds even when reset arrives in the middle of a stall.
- R2: A word whose syndrome is zero, accepted at edge T, appears on out_data in the cycle after T. In that cycle out_valid is 1 and out_fix and out_bad are 0. Such words can be accepted on every consecutive cycle.
- R3: A word whose syndrome is nonzero, accepted at edge T, holds out_stall at 1 and in_ready and out_valid at 0 for exactly STALL_CYC cycles after T.
- R4: A single flipped bit at any of the 26 codeword positions is corrected. The true data appears with out_valid and out_fix at 1 in cycle T+1+STALL_CYC, and only for that cycle.
- R5: Any two flipped bits at distinct positions are corrected, with the same timing and flags as R4.
- R6: If the syndrome matches no pattern of weight one or two, the raw data bits are delivered at the R4 timing with out_bad at 1 and out_fix at 0.
- R7: in_code[15:0] holds the data and in_code[25:16] holds the check bits. Check bit j is the XOR of the data bits i for which bit j of (x^(10+i) mod g(x)) is 1, where g(x) = x^10+x^9+x^8+x^6+x^5+x^3+1.
- R8: in_valid is ignored while in_ready is 0. A word offered during a stall is never captured and never delivered.
- R9: fix_count and bad_count each increase by one for every delivery carrying out_fix or out_bad, respectively. The new value is visible in the cycle after the delivery, and each counter stops at its all-ones value.
- R10: in_ready is 1 in the delivery cycle of a stalled word. A clean word accepted there appears on the next cycle, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A codeword is offered on in_code |
| in_code | input | 26 | Codeword from memory: check bits above data bits |
| in_ready | output | 1 | Stage accepts a codeword at the next edge |
| out_valid | output | 1 | out_data carries a read result this cycle |
| out_stall | output | 1 | Consumer must wait; correction in progress |
| out_data | output | 16 | Read data, raw or corrected |
| out_fix | output | 1 | Delivered word was corrected |
| out_bad | output | 1 | Delivered word holds an uncorrectable error |
| fix_count | output | 8 | Saturating count of corrected deliveries |
| bad_count | output | 8 | Saturating count of uncorrectable deliveries |

## Verification
The delivery of a stalled word and the acceptance of the next read happen in the same cycle. The bench provokes this by offering a clean word exactly on the cycle the corrected word comes out. It then checks that the corrected data and flag appear in that cycle, that in_ready is high there, and that the new word comes out unflagged one cycle later. A second case offers a word during the stall and withdraws it at delivery. It confirms that the withdrawn word never reaches the output, and that the counter update from the delivery still lands in the following cycle.

// File: rtl/ecc_fwd_pkg.sv
// Shared definitions for the early-forwarding ECC read stage.
// Assumes the check width is at most 31 bits so columns fit in 32 bits.
package ecc_fwd_pkg;

    // Phase of the read stage: forwarding, waiting on the decoder, delivering.
    typedef enum logic [1:0] {
        PH_PASS = 2'd0,
        PH_WAIT = 2'd1,
        PH_SEND = 2'd2
    } ph_e;

    // Parity column of data bit bit_idx: x^(chk_w+bit_idx) reduced by gpoly.
    function automatic logic [31:0] par_col(input int unsigned bit_idx,
                                            input int unsigned chk_w,
                                            input logic [32:0] gpoly);
        logic [32:0] acc;
        acc = 33'd1;
        for (int unsigned s = 0; s < chk_w + bit_idx; s++) begin
            acc = acc << 1;
            if (acc[chk_w]) acc = acc ^ gpoly;
        end
        return acc[31:0];
    endfunction

    // Syndrome column of codeword position pos (data first, check bits above).
    function automatic logic [31:0] code_col(input int unsigned pos,
                                             input int unsigned data_w,
                                             input int unsigned chk_w,
                                             input logic [32:0] gpoly);
        if (pos < data_w) return par_col(pos, chk_w, gpoly);
        return 32'd1 << (pos - data_w);
    endfunction

endpackage

// File: rtl/ecc_syn_gen.sv
// Syndrome generator: recomputes the check bits from the data part of a
// codeword and folds in the stored check bits. A zero result means the
// word is a valid codeword. Purely combinational, the same depth as an encoder.
module ecc_syn_gen #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CHK_W  = 10,
    parameter logic [CHK_W:0] GEN_POLY = 11'h769,
    localparam int unsigned N = DATA_W + CHK_W
) (
    input  logic [N-1:0]     code,
    output logic [CHK_W-1:0] syn
);
    logic [CHK_W-1:0] term [DATA_W];

    // One masked parity column per data bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_term
        localparam logic [31:0] COLF =
            ecc_fwd_pkg::code_col(i, DATA_W, CHK_W, 33'(GEN_POLY));
        localparam logic [CHK_W-1:0] COL = COLF[CHK_W-1:0];
        assign term[i] = code[i] ? COL : '0;
    end

    // XOR tree: stored check bits against the recomputed ones.
    always_comb begin
        syn = code[N-1:DATA_W];
        for (int i = 0; i < DATA_W; i++) syn = syn ^ term[i];
    end
endmodule

// File: rtl/ecc_dec2_fix.sv
// Pattern decoder for up to two bit errors. It compares the syndrome against
// every single-position column and every XOR of two distinct columns, flips
// the data bits covered by the match, and reports whether any match exists.
// Assumes the code distance is at least five, so matches are unique.
module ecc_dec2_fix #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CHK_W  = 10,
    parameter logic [CHK_W:0] GEN_POLY = 11'h769,
    localparam int unsigned N = DATA_W + CHK_W
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [CHK_W-1:0]  syn,
    output logic [DATA_W-1:0] data_fix,
    output logic              fixable
);
    logic [N-1:0]   single_hit;
    logic [N*N-1:0] pair_hit;
    logic [DATA_W-1:0] flip;

    // Comparator array: upper triangle holds the pair matches.
    for (genvar a = 0; a < N; a++) begin : g_a
        localparam logic [31:0] COLAF =
            ecc_fwd_pkg::code_col(a, DATA_W, CHK_W, 33'(GEN_POLY));
        localparam logic [CHK_W-1:0] COLA = COLAF[CHK_W-1:0];
        assign single_hit[a] = (syn == COLA);
        for (genvar b = 0; b < N; b++) begin : g_b
            if (b > a) begin : g_pair
                localparam logic [31:0] COLBF =
                    ecc_fwd_pkg::code_col(b, DATA_W, CHK_W, 33'(GEN_POLY));
                localparam logic [CHK_W-1:0] COLB = COLBF[CHK_W-1:0];
                assign pair_hit[a*N+b] = (syn == (COLA ^ COLB));
            end else begin : g_none
                assign pair_hit[a*N+b] = 1'b0;
            end
        end
    end

    // A data bit flips when a matched pattern includes it.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            flip[i] = single_hit[i];
            for (int j = 0; j < N; j++) begin
                if (j > i)      flip[i] = flip[i] | pair_hit[i*N+j];
                else if (j < i) flip[i] = flip[i] | pair_hit[j*N+i];
            end
        end
    end

    // Corrected data and the correctable verdict.
    assign data_fix = data_in ^ flip;
    assign fixable  = (|single_hit) | (|pair_hit);
endmodule

// File: rtl/ecc_evt_cnt.sv
// Saturating event counter. It counts cycles with inc high and stops at
// all ones. Assumes inc is a single-cycle pulse per event.
module ecc_evt_cnt #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count up to the ceiling and then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (inc && cnt != CNT_MAX)   cnt <= cnt + 1'b1;
    end

    assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) |=> (cnt == CNT_MAX));
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc) |=> $stable(cnt));
endmodule

// File: rtl/ecc_fwd_ctrl.sv
// Read-stage control: holds the captured codeword, forwards clean data at
// once, and on a nonzero syndrome stalls for STALL_CYC cycles before
// delivering the registered decoder output for one cycle.
// Assumes STALL_CYC >= 1. The decoder path from stage_code into the hold
// register is given STALL_CYC cycles.
module ecc_fwd_ctrl #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CHK_W     = 10,
    parameter int unsigned STALL_CYC = 2,
    localparam int unsigned N  = DATA_W + CHK_W,
    localparam int unsigned CW = (STALL_CYC > 1) ? $clog2(STALL_CYC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [N-1:0]      in_code,
    input  logic              syn_zero,
    input  logic [DATA_W-1:0] fix_data,
    input  logic              fixable,
    output logic [N-1:0]      stage_code,
    output logic              in_ready,
    output logic              out_valid,
    output logic              out_stall,
    output logic [DATA_W-1:0] out_data,
    output logic              out_fix,
    output logic              out_bad
);
    ecc_fwd_pkg::ph_e ph;
    logic              stage_vld;
    logic [CW-1:0]     wait_cnt;
    logic [DATA_W-1:0] hold_data;
    logic              hold_bad;
    logic              err_now;
    logic              enter_send;

    // Error seen on a freshly captured word, and the last stall cycle.
    assign err_now    = (ph == ecc_fwd_pkg::PH_PASS) && stage_vld && !syn_zero;
    assign enter_send = (err_now && (STALL_CYC == 1)) ||
                        ((ph == ecc_fwd_pkg::PH_WAIT) && (wait_cnt == CW'(STALL_CYC - 1)));

    // Handshake and stall toward producer and consumer.
    assign out_stall = err_now || (ph == ecc_fwd_pkg::PH_WAIT);
    assign in_ready  = !out_stall;

    // Stage register: load whenever ready, freeze during a stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_vld  <= 1'b0;
            stage_code <= '0;
        end else if (in_ready) begin
            stage_vld  <= in_valid;
            stage_code <= in_code;
        end
    end

    // Phase sequencing through the stall window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= ecc_fwd_pkg::PH_PASS;
            wait_cnt <= '0;
        end else begin
            case (ph)
                ecc_fwd_pkg::PH_PASS: begin
                    if (err_now) begin
                        if (STALL_CYC == 1) ph <= ecc_fwd_pkg::PH_SEND;
                        else                ph <= ecc_fwd_pkg::PH_WAIT;
                        wait_cnt <= CW'(1);
                    end
                end
                ecc_fwd_pkg::PH_WAIT: begin
                    if (enter_send) ph <= ecc_fwd_pkg::PH_SEND;
                    else            wait_cnt <= wait_cnt + 1'b1;
                end
                default: ph <= ecc_fwd_pkg::PH_PASS;
            endcase
        end
    end

    // Capture the decoder result at the end of the stall window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_bad  <= 1'b0;
        end else if (enter_send) begin
            hold_data <= fix_data;
            hold_bad  <= !fixable;
        end
    end

    // Output select: raw forward when clean, held result when delivering.
    always_comb begin
        if (ph == ecc_fwd_pkg::PH_SEND) begin
            out_valid = 1'b1;
            out_data  = hold_data;
            out_fix   = !hold_bad;
            out_bad   = hold_bad;
        end else begin
            out_valid = (ph == ecc_fwd_pkg::PH_PASS) && stage_vld && syn_zero;
            out_data  = stage_code[DATA_W-1:0];
            out_fix   = 1'b0;
            out_bad   = 1'b0;
        end
    end

    // Checker state: length of the current run of stall cycles.
    logic [7:0] chk_run;
    always_ff @(posedge clk) begin
        if (!rst_n) chk_run <= '0;
        else        chk_run <= out_stall ? chk_run + 8'd1 : 8'd0;
    end

    assert_stall_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fix || out_bad) |-> (chk_run == 8'(STALL_CYC)));
    assert_stage_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_stall |=> $stable(stage_code));
    assert_fix_weight_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_fix |-> ($countones(out_data ^ stage_code[DATA_W-1:0]) <= 2));
    assert_raw_on_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_bad |-> (out_data == stage_code[DATA_W-1:0]));
    assert_ready_at_send_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fix || out_bad) |-> $past(out_stall) && in_ready);
endmodule

// File: rtl/ecc_fwd_read.sv
// Top of the early-forwarding ECC read stage. The syndrome of the captured
// word decides between forwarding at once and stalling for the two-error
// pattern decoder. Saturating counters tally the delivered outcomes.
// Assumes the memory returns words in the layout checked by ecc_syn_gen.
module ecc_fwd_read #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CHK_W     = 10,
    parameter logic [CHK_W:0] GEN_POLY = 11'h769,
    parameter int unsigned STALL_CYC = 2,
    parameter int unsigned CNT_W     = 8,
    localparam int unsigned N = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [N-1:0]      in_code,
    output logic              in_ready,
    output logic              out_valid,
    output logic              out_stall,
    output logic [DATA_W-1:0] out_data,
    output logic              out_fix,
    output logic              out_bad,
    output logic [CNT_W-1:0]  fix_count,
    output logic [CNT_W-1:0]  bad_count
);
    logic [N-1:0]      stage_code;
    logic [CHK_W-1:0]  syn;
    logic              syn_zero;
    logic [DATA_W-1:0] fix_data;
    logic              fixable;

    ecc_syn_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W), .GEN_POLY(GEN_POLY)) u_syn (
        .code (stage_code),
        .syn  (syn)
    );

    // Fast zero test on the syndrome.
    assign syn_zero = ~|syn;

    ecc_dec2_fix #(.DATA_W(DATA_W), .CHK_W(CHK_W), .GEN_POLY(GEN_POLY)) u_dec (
        .data_in  (stage_code[DATA_W-1:0]),
        .syn      (syn),
        .data_fix (fix_data),
        .fixable  (fixable)
    );

    ecc_fwd_ctrl #(.DATA_W(DATA_W), .CHK_W(CHK_W), .STALL_CYC(STALL_CYC)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_code    (in_code),
        .syn_zero   (syn_zero),
        .fix_data   (fix_data),
        .fixable    (fixable),
        .stage_code (stage_code),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_stall  (out_stall),
        .out_data   (out_data),
        .out_fix    (out_fix),
        .out_bad    (out_bad)
    );

    ecc_evt_cnt #(.CNT_W(CNT_W)) u_cnt_fix (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (out_fix),
        .cnt   (fix_count)
    );

    ecc_evt_cnt #(.CNT_W(CNT_W)) u_cnt_bad (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (out_bad),
        .cnt   (bad_count)
    );
endmodule

// File: tb/tb_ecc_fwd_read.sv
module tb_ecc_fwd_read;
    localparam int CLK_P    = 10;
    localparam int KW       = 16;
    localparam int RW       = 10;
    localparam int NW       = 26;
    localparam int TB_STALL = 2;
    localparam int CW       = 8;
    localparam logic [RW:0] GPOLY = 11'h769;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [NW-1:0] in_code = '0;
    logic          in_ready, out_valid, out_stall, out_fix, out_bad;
    logic [KW-1:0] out_data;
    logic [CW-1:0] fix_count, bad_count;

    int checks = 0;
    int errors = 0;
    int exp_fix = 0;
    int exp_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    ecc_fwd_read #(.STALL_CYC(TB_STALL), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
        .in_ready(in_ready), .out_valid(out_valid), .out_stall(out_stall),
        .out_data(out_data), .out_fix(out_fix), .out_bad(out_bad),
        .fix_count(fix_count), .bad_count(bad_count)
    );

    // Vector table: {data, error mask over the 26 codeword bits}.
    localparam logic [41:0] VEC [12] = '{
        {16'h0000, 26'h0000000}, {16'hFFFF, 26'h0000000},
        {16'hA5C3, 26'h0000001}, {16'h1234, 26'h0008000},
        {16'h8001, 26'h0010000}, {16'h7E7E, 26'h2000000},
        {16'hC0DE, 26'h0000003}, {16'h0F0F, 26'h2008000},
        {16'h5555, 26'h2010000}, {16'hBEEF, 26'h0100008},
        {16'h3333, 26'h0000007}, {16'h9999, 26'h0420200}
    };

    // Check bits by long division of d(x)*x^10 by the generator (R7).
    function automatic logic [RW-1:0] enc(input logic [KW-1:0] d);
        logic [NW-1:0] r;
        r = {d, {RW{1'b0}}};
        for (int b = NW - 1; b >= RW; b--)
            if (r[b]) r = r ^ (NW'(GPOLY) << (b - RW));
        return r[RW-1:0];
    endfunction

    function automatic logic [RW-1:0] syn_of(input logic [NW-1:0] c);
        return enc(c[KW-1:0]) ^ c[NW-1:KW];
    endfunction

    function automatic int sat(input int v);
        return (v > 255) ? 255 : v;
    endfunction

    // Expected outcome: 0 clean, 1 corrected, 2 uncorrectable.
    task automatic model(input logic [NW-1:0] c, output int kind, output logic [KW-1:0] d);
        logic [RW-1:0] s;
        logic [NW-1:0] e;
        s = syn_of(c);
        d = c[KW-1:0];
        kind = 0;
        if (s != '0) begin
            kind = 2;
            for (int a = 0; a < NW; a++)
                for (int b = a; b < NW; b++) begin
                    e = (NW'(1) << a) | (NW'(1) << b);
                    if (kind == 2 && syn_of(e) == s) begin
                        kind = 1;
                        d = c[KW-1:0] ^ e[KW-1:0];
                    end
                end
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_counts();
        check(fix_count == CW'(sat(exp_fix)) && bad_count == CW'(sat(exp_bad)), "R9",
              32'({fix_count, bad_count}), 32'({CW'(sat(exp_fix)), CW'(sat(exp_bad))}));
    endtask

    // One read with full timing checks, then a counter check.
    task automatic read_word(input logic [KW-1:0] d, input logic [NW-1:0] emask);
        logic [NW-1:0] code;
        logic [KW-1:0] ed;
        int kind;
        string tag;
        code = {enc(d), d} ^ emask;
        model(code, kind, ed);
        if (kind == 0)                    tag = "R2 R7";
        else if (kind == 2)               tag = "R6";
        else if ($countones(emask) == 1)  tag = "R4";
        else if ($countones(emask) == 2)  tag = "R5";
        else                              tag = "R6";
        @(negedge clk);
        in_valid = 1'b1;
        in_code  = code;
        @(negedge clk);
        in_valid = 1'b0;
        if (kind == 0) begin
            check(out_valid && !out_fix && !out_bad && out_data == ed, tag,
                  32'({out_valid, out_fix, out_bad, out_data}), 32'({3'b100, ed}));
        end else begin
            for (int k = 0; k < TB_STALL; k++) begin
                check(out_stall && !in_ready && !out_valid, "R3",
                      32'({out_stall, in_ready, out_valid}), 32'(3'b100));
                @(negedge clk);
            end
            check(out_valid && out_fix == (kind == 1) && out_bad == (kind == 2) && out_data == ed, tag,
                  32'({out_valid, out_fix, out_bad, out_data}),
                  32'({1'b1, kind == 1, kind == 2, ed}));
            if (kind == 1) exp_fix++;
            else           exp_bad++;
        end
        @(negedge clk);
        check(!out_valid, tag, 32'(out_valid), 32'(0));
        check_counts();
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL R2 watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NW-1:0] c1, c2;
        logic [KW-1:0] ed;
        int kind;
        bit found;

        // R1: state during and after reset.
        repeat (3) @(negedge clk);
        check(in_ready && !out_valid && !out_stall && fix_count == 0 && bad_count == 0, "R1",
              32'({in_ready, out_valid, out_stall, fix_count, bad_count}), 32'({3'b100, 16'h0}));
        rst_n = 1'b1;

        // Table walk.
        for (int v = 0; v < 12; v++) read_word(VEC[v][41:26], VEC[v][25:0]);

        // R2: back-to-back clean words, one per cycle.
        @(negedge clk);
        in_valid = 1'b1; in_code = {enc(16'h1111), 16'h1111};
        @(negedge clk);
        in_code = {enc(16'h2222), 16'h2222};
        check(out_valid && out_data == 16'h1111 && in_ready, "R2", 32'(out_data), 32'h1111);
        @(negedge clk);
        in_code = {enc(16'h4444), 16'h4444};
        check(out_valid && out_data == 16'h2222 && in_ready, "R2", 32'(out_data), 32'h2222);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_data == 16'h4444 && !out_fix, "R2", 32'(out_data), 32'h4444);
        @(negedge clk);
        check(!out_valid, "R2", 32'(out_valid), 32'(0));

        // R8: a word offered during the stall is not taken.
        c1 = {enc(16'h3C3C), 16'h3C3C} ^ 26'h0000010;
        in_valid = 1'b1; in_code = c1;
        @(negedge clk);
        in_code = {enc(16'h6666), 16'h6666};
        check(out_stall && !in_ready, "R8", 32'({out_stall, in_ready}), 32'(2'b10));
        for (int k = 1; k < TB_STALL; k++) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_fix && out_data == 16'h3C3C, "R8", 32'(out_data), 32'h3C3C);
        exp_fix++;
        @(negedge clk);
        check(!out_valid && !out_stall, "R8", 32'({out_valid, out_stall}), 32'(0));
        check_counts();

        // R10: delivery and acceptance of the next clean word in one cycle.
        c2 = {enc(16'hD00D), 16'hD00D} ^ 26'h1000400;
        in_valid = 1'b1; in_code = c2;
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < TB_STALL; k++) @(negedge clk);
        check(in_ready && out_valid && out_fix && out_data == 16'hD00D, "R10",
              32'({in_ready, out_valid, out_fix, out_data}), 32'({3'b111, 16'hD00D}));
        exp_fix++;
        in_valid = 1'b1; in_code = {enc(16'h7777), 16'h7777};
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && !out_fix && !out_bad && out_data == 16'h7777, "R10",
              32'({out_valid, out_fix, out_bad, out_data}), 32'({3'b100, 16'h7777}));
        check_counts();

        // R4: every single-bit position.
        for (int p = 0; p < NW; p++) read_word(16'(16'hA000 + p * 313), NW'(1) << p);
        // R5: pairs with the lowest and the highest position.
        for (int p = 1; p < NW; p++) read_word(16'(p * 1021), (NW'(1) << p) | NW'(1));
        for (int p = 0; p < NW - 1; p++) read_word(16'(p * 777 + 5), (NW'(1) << p) | (NW'(1) << (NW - 1)));

        // R6: find a triple the model calls uncorrectable and apply it.
        found = 1'b0;
        for (int p = 2; p < NW; p++) begin
            c1 = {enc(16'h4242), 16'h4242} ^ (26'h3 | (NW'(1) << p));
            model(c1, kind, ed);
            if (!found && kind == 2) begin
                found = 1'b1;
                read_word(16'h4242, 26'h3 | (NW'(1) << p));
            end
        end
        check(found, "R6", 32'(found), 32'(1));
        check(bad_count != 0, "R6", 32'(bad_count), 32'(1));

        // R9: drive the corrected counter past its ceiling.
        for (int i = 0; exp_fix < 260; i++) read_word(16'(i * 40503), NW'(1) << (i % NW));
        check(fix_count == 8'hFF, "R9", 32'(fix_count), 32'hFF);

        // R1: reset in the middle of a stall.
        @(negedge clk);
        in_valid = 1'b1; in_code = {enc(16'h0101), 16'h0101} ^ 26'h0000100;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(in_ready && !out_stall && !out_valid && fix_count == 0 && bad_count == 0, "R1",
              32'({in_ready, out_stall, out_valid, fix_count, bad_count}), 32'({3'b100, 16'h0}));
        rst_n = 1'b1;
        exp_fix = 0;
        exp_bad = 0;
        read_word(16'hFACE, 26'h0);
        read_word(16'hCAFE, 26'h0000200);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule